// File: doc/BRIEF.md
# Subcarrier-Locked Pixel Clock Divider Chain

This block is the digital half of a phase-locked loop that ties a video pixel clock to a colour subcarrier. The subcarrier clock is divided down to a low-rate reference tone. The pixel clock comes from an external oscillator and is passed through a buffer. A two-stage chain running from the buffered clock divides it down to a feedback tone of the same nominal rate: a line-length stage first, then a short post stage. With the default ratios (1136 for the reference against 684 × 4 for the feedback), a 4.433618 MHz subcarrier and a 10.67815 MHz pixel clock meet at about 3.903 kHz.

The line-length stage also defines the horizontal line. An active-low horizontal sync pulse starts on the first pixel clock of each line and lasts a run-time width. That pulse is combined with an external active-low vertical sync to form one composite reference sync. A digital phase-frequency detector works in the pixel clock domain. It synchronises the reference tone, watches the rising edges of both tones, and drives up/down requests toward an analog loop filter outside the block.

Top module: `subcarrier_lock_divider`

## Requirements
- R1: Starting from the first subcarrier clock after reset is released, `ref_tone` is high for REF_DIV/2 subcarrier clocks and then low for the rest of a REF_DIV-clock period. This repeats with no gaps.
- R2: Starting from the first pixel clock after reset, `fb_tone` is high for the first FB_POST_DIV/2 lines of every FB_POST_DIV-line period and low for the rest. A line is LINE_DIV pixel clocks. `fb_tone` rises only on the first clock of a line.
- R3: Lines begin on the first pixel clock after reset and then every LINE_DIV clocks. `hsync_n` is low on clocks 0 .. min(hsync_len, LINE_DIV)-1 of each line and high otherwise. `hsync_len` is sampled on every clock, so `hsync_len` = 0 gives no pulse and `hsync_len` ≥ LINE_DIV holds it low.
- R4: `csync_n` is low whenever `hsync_n` or `vsync_n_in` is low, and high otherwise.
- R5: `clk_pix_out` follows `clk_pix_in`. All pixel-domain logic is clocked from `clk_pix_out`.
- R6: `ref_tone` passes through a two-flop synchroniser. A reference rise acts on the second pixel clock edge after the first edge that samples `ref_tone` high. A feedback rise acts on the pixel edge after the edge at which `fb_tone` went high. When both rises act on the same edge, both outputs clear. A reference rise alone clears `pfd_dn` if it is set, and otherwise sets `pfd_up`. A feedback rise alone clears `pfd_up` if it is set, and otherwise sets `pfd_dn`. `pfd_up` and `pfd_dn` are never high together.
- R7: `rst` is synchronous and active high in both domains. While it is applied, `ref_tone`, `fb_tone`, `pfd_up` and `pfd_dn` go low and `hsync_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sc | input | 1 | Colour subcarrier clock |
| clk_pix_in | input | 1 | Pixel clock from the external oscillator |
| rst | input | 1 | Synchronous active-high reset |
| vsync_n_in | input | 1 | External vertical sync, active low |
| hsync_len | input | LEN_W | Horizontal sync width in pixel clocks |
| clk_pix_out | output | 1 | Buffered pixel clock |
| ref_tone | output | 1 | Divided subcarrier reference tone |
| fb_tone | output | 1 | Divided pixel clock feedback tone |
| hsync_n | output | 1 | Line-rate horizontal sync, active low |
| csync_n | output | 1 | Composite reference sync, active low |
| pfd_up | output | 1 | Request to raise oscillator frequency |
| pfd_dn | output | 1 | Request to lower oscillator frequency |

## Verification
The bench builds the block with REF_DIV = 20, LINE_DIV = 12 and FB_POST_DIV = 4, so a feedback period is 48 pixel clocks and a few thousand cycles cover dozens of detector comparisons. At a 125 MHz pixel clock, the bench runs the subcarrier first slightly slow (reference period about 48.25 pixel clocks) and then clearly fast (about 42.75). This puts the detector into its down-dominant regime and then its up-dominant regime, with the leading edge slowly drifting. The small line length lets sync widths of zero, mid-line and a full line each be seen over many lines while vertical sync is toggled.

// File: rtl/scd_pkg.sv
package scd_pkg;

   typedef enum logic [1:0] {
      PFD_IDLE = 2'b00,
      PFD_UP   = 2'b01,
      PFD_DN   = 2'b10
   } pfd_state_t;

   function automatic int unsigned cnt_width(input int unsigned modulus);
      return (modulus > 1) ? $clog2(modulus) : 1;
   endfunction

endpackage

// File: rtl/scd_divider.sv
module scd_divider #(
   parameter int unsigned DIV = 4,
   parameter int unsigned CW  = scd_pkg::cnt_width(DIV)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   output logic [CW-1:0] cnt_o,
   output logic          tick_o,
   output logic          tone_o
);
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);
   localparam logic [CW-1:0] HALF = CW'(DIV / 2);

   if (DIV < 2) begin : g_bad_div
      $error("scd_divider: DIV must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nxt;
   logic          tone_q;

   assign tick_o  = en && (cnt_q == LAST);
   assign cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= LAST;
         tone_q <= 1'b0;
      end else if (en) begin
         cnt_q  <= cnt_nxt;
         tone_q <= (cnt_nxt < HALF);
      end
   end

   assign cnt_o  = cnt_q;
   assign tone_o = tone_q;
endmodule

// File: rtl/scd_line_sync.sv
module scd_line_sync #(
   parameter int unsigned LINE  = 684,
   parameter int unsigned CW    = 10,
   parameter int unsigned LEN_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CW-1:0]    line_cnt,
   input  logic [LEN_W-1:0] len,
   output logic             hsync_n_o
);
   localparam int unsigned   MW   = (CW > LEN_W) ? CW : LEN_W;
   localparam logic [CW-1:0] LAST = CW'(LINE - 1);

   logic [CW-1:0] pos_nxt;
   logic [MW-1:0] pos_w;
   logic [MW-1:0] len_w;
   logic          hs_q;

   assign pos_nxt = (line_cnt == LAST) ? '0 : line_cnt + 1'b1;
   assign pos_w   = MW'(pos_nxt);
   assign len_w   = MW'(len);

   always_ff @(posedge clk) begin
      if (rst) hs_q <= 1'b1;
      else     hs_q <= !(pos_w < len_w);
   end

   assign hsync_n_o = hs_q;
endmodule

// File: rtl/scd_pfd.sv
module scd_pfd
   import scd_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_i,
   input  logic fb_i,
   output logic up_o,
   output logic dn_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("scd_pfd: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] ref_sync;
   logic                   ref_prev;
   logic                   fb_prev;
   logic                   ref_rise;
   logic                   fb_rise;
   pfd_state_t             st_q;
   pfd_state_t             st_d;

   assign ref_rise = ref_sync[SYNC_STAGES-1] && !ref_prev;
   assign fb_rise  = fb_i && !fb_prev;

   always_comb begin
      st_d = st_q;
      if (ref_rise && fb_rise)  st_d = PFD_IDLE;
      else if (ref_rise)        st_d = (st_q == PFD_DN) ? PFD_IDLE : PFD_UP;
      else if (fb_rise)         st_d = (st_q == PFD_UP) ? PFD_IDLE : PFD_DN;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ref_sync <= '0;
         ref_prev <= 1'b0;
         fb_prev  <= 1'b0;
         st_q     <= PFD_IDLE;
      end else begin
         ref_sync <= {ref_sync[SYNC_STAGES-2:0], ref_i};
         ref_prev <= ref_sync[SYNC_STAGES-1];
         fb_prev  <= fb_i;
         st_q     <= st_d;
      end
   end

   assign up_o = (st_q == PFD_UP);
   assign dn_o = (st_q == PFD_DN);
endmodule

// File: rtl/subcarrier_lock_divider.sv
module subcarrier_lock_divider #(
   parameter int unsigned REF_DIV     = 1136,
   parameter int unsigned LINE_DIV    = 684,
   parameter int unsigned FB_POST_DIV = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LEN_W       = $clog2(LINE_DIV + 1)
) (
   input  logic             clk_sc,
   input  logic             clk_pix_in,
   input  logic             rst,
   input  logic             vsync_n_in,
   input  logic [LEN_W-1:0] hsync_len,
   output logic             clk_pix_out,
   output logic             ref_tone,
   output logic             fb_tone,
   output logic             hsync_n,
   output logic             csync_n,
   output logic             pfd_up,
   output logic             pfd_dn
);
   localparam int unsigned REF_CW  = scd_pkg::cnt_width(REF_DIV);
   localparam int unsigned LINE_CW = scd_pkg::cnt_width(LINE_DIV);
   localparam int unsigned FB_CW   = scd_pkg::cnt_width(FB_POST_DIV);

   if (LINE_DIV < 2) begin : g_bad_line
      $error("subcarrier_lock_divider: LINE_DIV must be at least 2");
   end
   if (FB_POST_DIV < 1) begin : g_bad_post
      $error("subcarrier_lock_divider: FB_POST_DIV must be at least 1");
   end

   logic [REF_CW-1:0]  ref_cnt;
   logic               ref_tick;
   logic [LINE_CW-1:0] line_cnt;
   logic               line_tick;
   logic               line_tone;
   logic [FB_CW-1:0]   fb_cnt;
   logic               fb_tick;

   assign clk_pix_out = clk_pix_in;

   scd_divider #(.DIV(REF_DIV), .CW(REF_CW)) u_ref_div (
      .clk(clk_sc), .rst(rst), .en(1'b1),
      .cnt_o(ref_cnt), .tick_o(ref_tick), .tone_o(ref_tone)
   );

   scd_divider #(.DIV(LINE_DIV), .CW(LINE_CW)) u_line_div (
      .clk(clk_pix_out), .rst(rst), .en(1'b1),
      .cnt_o(line_cnt), .tick_o(line_tick), .tone_o(line_tone)
   );

   if (FB_POST_DIV == 1) begin : g_post_bypass
      assign fb_tone = line_tone;
      assign fb_cnt  = '0;
      assign fb_tick = 1'b0;
   end else begin : g_post_div
      scd_divider #(.DIV(FB_POST_DIV), .CW(FB_CW)) u_post_div (
         .clk(clk_pix_out), .rst(rst), .en(line_tick),
         .cnt_o(fb_cnt), .tick_o(fb_tick), .tone_o(fb_tone)
      );
   end

   scd_line_sync #(.LINE(LINE_DIV), .CW(LINE_CW), .LEN_W(LEN_W)) u_hsync (
      .clk(clk_pix_out), .rst(rst), .line_cnt(line_cnt),
      .len(hsync_len), .hsync_n_o(hsync_n)
   );

   assign csync_n = hsync_n & vsync_n_in;

   scd_pfd #(.SYNC_STAGES(SYNC_STAGES)) u_pfd (
      .clk(clk_pix_out), .rst(rst), .ref_i(ref_tone), .fb_i(fb_tone),
      .up_o(pfd_up), .dn_o(pfd_dn)
   );
endmodule

// File: rtl/scd_checker.sv
module scd_checker #(
   parameter int unsigned LEN_W   = 10,
   parameter int unsigned REF_CW  = 11,
   parameter int unsigned FB_CW   = 2
) (
   input logic              clk_sc,
   input logic              clk_pix,
   input logic              rst,
   input logic              vsync_n_in,
   input logic [LEN_W-1:0]  hsync_len,
   input logic              ref_tone,
   input logic [REF_CW-1:0] ref_cnt,
   input logic              ref_tick,
   input logic              fb_tone,
   input logic [FB_CW-1:0]  fb_cnt,
   input logic              fb_tick,
   input logic              line_tone,
   input logic              hsync_n,
   input logic              csync_n,
   input logic              pfd_up,
   input logic              pfd_dn
);
   p_ref_rise_r1: assert property (@(posedge clk_sc) disable iff (rst)
      $rose(ref_tone) |-> (ref_cnt == '0));

   p_ref_wrap_r1: assert property (@(posedge clk_sc) disable iff (rst)
      ref_tick |=> ref_tone);

   p_fb_wrap_r2: assert property (@(posedge clk_pix) disable iff (rst)
      fb_tick |=> fb_tone);

   p_fb_rise_r2: assert property (@(posedge clk_pix) disable iff (rst)
      $rose(fb_tone) |-> ((fb_cnt == '0) && $rose(line_tone)));

   p_hs_start_r3: assert property (@(posedge clk_pix) disable iff (rst)
      ($rose(line_tone) && ($past(hsync_len) != '0)) |-> !hsync_n);

   p_csync_v_r4: assert property (@(posedge clk_pix) disable iff (rst)
      !vsync_n_in |-> !csync_n);

   p_updn_excl_r6: assert property (@(posedge clk_pix) disable iff (rst)
      !(pfd_up && pfd_dn));

   p_dn_cause_r6: assert property (@(posedge clk_pix) disable iff (rst)
      $rose(pfd_dn) |-> ($past(fb_tone, 1) && !$past(fb_tone, 2)));

   p_reset_r7: assert property (@(posedge clk_pix)
      rst |=> (!pfd_up && !pfd_dn && hsync_n && !fb_tone));
endmodule

bind subcarrier_lock_divider scd_checker #(
   .LEN_W(LEN_W), .REF_CW(REF_CW), .FB_CW(FB_CW)
) u_chk (
   .clk_sc(clk_sc), .clk_pix(clk_pix_out), .rst(rst),
   .vsync_n_in(vsync_n_in), .hsync_len(hsync_len),
   .ref_tone(ref_tone), .ref_cnt(ref_cnt), .ref_tick(ref_tick),
   .fb_tone(fb_tone), .fb_cnt(fb_cnt), .fb_tick(fb_tick),
   .line_tone(line_tone), .hsync_n(hsync_n), .csync_n(csync_n),
   .pfd_up(pfd_up), .pfd_dn(pfd_dn)
);

// File: tb/subcarrier_lock_divider_tb.sv
`timescale 1ns/1ps
module subcarrier_lock_divider_tb;
   localparam int REF  = 20;
   localparam int LINE = 12;
   localparam int POST = 4;
   localparam int LW   = $clog2(LINE + 1);

   logic clk_pix = 1'b0;
   logic clk_sc  = 1'b0;
   logic rst     = 1'b1;
   logic vsync_n = 1'b1;
   logic [LW-1:0] hs_len = LW'(3);
   logic clk_pix_out, ref_tone, fb_tone, hsync_n, csync_n, pfd_up, pfd_dn;
   realtime sc_half = 9.65;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   subcarrier_lock_divider #(
      .REF_DIV(REF), .LINE_DIV(LINE), .FB_POST_DIV(POST), .SYNC_STAGES(2)
   ) u_dut (
      .clk_sc(clk_sc), .clk_pix_in(clk_pix), .rst(rst), .vsync_n_in(vsync_n),
      .hsync_len(hs_len), .clk_pix_out(clk_pix_out), .ref_tone(ref_tone),
      .fb_tone(fb_tone), .hsync_n(hsync_n), .csync_n(csync_n),
      .pfd_up(pfd_up), .pfd_dn(pfd_dn)
   );

   always #4 clk_pix = ~clk_pix;

   initial begin
      #1.234;
      forever begin
         clk_sc = 1'b1; #(sc_half);
         clk_sc = 1'b0; #(sc_half);
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // reference model: subcarrier domain
   int  m = 0;
   bit  ref_exp = 1'b0;
   always @(posedge clk_sc) begin
      if (rst) begin
         m = 0; ref_exp = 1'b0;
      end else begin
         m++;
         ref_exp = (((m - 1) % REF) < REF / 2);
      end
   end

   // reference model: pixel domain
   int  n = 0;
   bit  hs_exp = 1'b1, fb_exp = 1'b0, up_m = 1'b0, dn_m = 1'b0;
   bit  rh0 = 1'b0, rh1 = 1'b0, rh2 = 1'b0, f_last = 1'b0;
   int  up_cyc = 0, dn_cyc = 0;
   always @(posedge clk_pix) begin
      bit rr, fr;
      if (rst) begin
         n = 0; hs_exp = 1'b1; fb_exp = 1'b0; up_m = 1'b0; dn_m = 1'b0;
         rh0 = 1'b0; rh1 = 1'b0; rh2 = 1'b0; f_last = 1'b0;
      end else begin
         rr = rh1 && !rh2;
         fr = fb_tone && !f_last;
         f_last = fb_tone;
         rh2 = rh1; rh1 = rh0; rh0 = ref_tone;
         if (rr && fr) begin up_m = 1'b0; dn_m = 1'b0; end
         else if (rr) begin if (dn_m) dn_m = 1'b0; else up_m = 1'b1; end
         else if (fr) begin if (up_m) up_m = 1'b0; else dn_m = 1'b1; end
         n++;
         hs_exp = !(((n - 1) % LINE) < int'(hs_len));
         fb_exp = ((((n - 1) / LINE) % POST) < POST / 2);
         if (up_m) up_cyc++;
         if (dn_m) dn_cyc++;
      end
   end

   always @(negedge clk_sc) if (!done)
      chk(ref_tone == ref_exp, "R1", "ref_tone", ref_tone, ref_exp);

   always @(negedge clk_pix) if (!done) begin
      chk(fb_tone == fb_exp, "R2", "fb_tone", fb_tone, fb_exp);
      chk(hsync_n == hs_exp, "R3", "hsync_n", hsync_n, hs_exp);
      chk(csync_n == (hs_exp & vsync_n), "R4", "csync_n", csync_n, hs_exp & vsync_n);
      chk(clk_pix_out == clk_pix, "R5", "clk_pix_out", clk_pix_out, clk_pix);
      chk(pfd_up == up_m, "R6", "pfd_up", pfd_up, up_m);
      chk(pfd_dn == dn_m, "R6", "pfd_dn", pfd_dn, dn_m);
   end

   task automatic step(input int k);
      repeat (k) @(posedge clk_pix);
      #1;
   endtask

   task automatic reset_check();
      rst = 1'b1;
      step(6);
      @(negedge clk_pix);
      chk(!ref_tone && !fb_tone && hsync_n && !pfd_up && !pfd_dn, "R7", "reset state",
          {ref_tone, fb_tone, hsync_n, pfd_up, pfd_dn}, 5'b00100);
      step(1);
      rst = 1'b0;
   endtask

   initial begin
      step(2);
      reset_check();
      up_cyc = 0; dn_cyc = 0;
      for (int i = 0; i < 30; i++) begin
         step(50);
         vsync_n = (i % 4 != 3);
         if (i == 10) hs_len = '0;
         if (i == 18) hs_len = LW'(LINE);
         if (i == 24) hs_len = LW'(7);
      end
      chk(dn_cyc > up_cyc, "R6", "slow reference favours down", dn_cyc, up_cyc);
      sc_half = 8.55;
      reset_check();
      up_cyc = 0; dn_cyc = 0;
      for (int i = 0; i < 30; i++) begin
         step(50);
         vsync_n = (i % 3 != 1);
         hs_len = LW'(i % (LINE + 2));
      end
      chk(up_cyc > dn_cyc, "R6", "fast reference favours up", up_cyc, dn_cyc);
      step(2);
      reset_check();
      step(100);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 50000);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule